// File: doc/BRIEF.md
# BCD Time Entry Validator

This block sits between a register bus decoder and the time-of-day counters of a real-time clock. Each value that software writes into the time, weekday, time-alarm or weekday-alarm register arrives here first. The block checks every BCD digit and every field range, and it uses the 12/24-hour mode bit and the PM bit to choose the hour rule. It then raises a load enable for the target register, or it withholds that enable. A word with any bad field is dropped whole, so no part of it reaches a counter.

Two sticky flags record whether the last write to the time register and the last write to the weekday register were rejected. Software has no way to clear these flags directly. A flag drops only when a later write to the same register passes every check. Alarm writes go through the same checks but never touch the flags. The checks are combinational on the write data, so a load enable appears in the same cycle as the write strobe.

Top module: `bcd_entry_validator`

## Requirements
- R1: A calendar or calendar-alarm word is accepted only if its weekday field, bits [3:0], holds a value from 1 to 7.
- R2: With `hour12Mode` = 0, an hour field in bits [21:16] (tens digit [21:20], units [19:16]) is accepted only as BCD 00 to 23, and the PM bit 22 must be 0.
- R3: With `hour12Mode` = 1, the hour field is accepted only as BCD 01 to 12, and the PM bit 22 may have either value.
- R4: The minute field in bits [14:8] (tens digit [14:12], units [11:8]) is accepted only as BCD 00 to 59.
- R5: The second field in bits [6:0] (tens digit [6:4], units [3:0]) is accepted only as BCD 00 to 59. A units digit above 9 is illegal in every field.
- R6: Target codes are time = 0, calendar = 1, time alarm = 2 and calendar alarm = 3. The matching load enable is high in the same cycle as `wrStrobe` when the word passes. With no strobe, no load enable is high, and at most one load enable is ever high.
- R7: If any checked field of a word fails, no load enable is raised for that write. The word is rejected as a whole.
- R8: `timeBad` is set after a failing time write and cleared after a passing time write. Nothing else changes it.
- R9: `calBad` is set after a failing calendar write and cleared after a passing calendar write. Nothing else changes it.
- R10: Time-alarm words get the same checks as time words, and calendar-alarm words the same checks as calendar words. Alarm writes never change either flag.
- R11: Reset (`rstN` low) clears both flags to 0.
- R12: Bits outside the checked fields (7, 15, 23, 31:24 of time-type words; 31:4 of calendar-type words) have no effect on acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | Write request this cycle |
| wrTarget | input | 2 | Target register code |
| wrData | input | DATA_W | Written data word |
| hour12Mode | input | 1 | 1 selects 12-hour checking |
| loadTime | output | 1 | Load enable, time register |
| loadCal | output | 1 | Load enable, calendar register |
| loadTimeAlarm | output | 1 | Load enable, time-alarm register |
| loadCalAlarm | output | 1 | Load enable, calendar-alarm register |
| timeBad | output | 1 | Sticky non-valid flag for time writes |
| calBad | output | 1 | Sticky non-valid flag for calendar writes |

## Verification
The hardest state to reach from the ports is a flag clearing after a long run of unrelated traffic. To get there, a time write must fail first, then several alarm and calendar writes must go by without disturbing the flag, and only then must a passing time write arrive. The stimulus builds exactly that sequence for both flags. It also sweeps every hour code under both hour modes with the PM bit at each value, and every minute, second and weekday code. The corner values 00, 12, 23, 59 and the non-decimal digits are therefore all covered in both directions.

// File: rtl/entryPkg.sv
package entryPkg;

  typedef enum logic [1:0] {
    TGT_TIME = 2'd0,
    TGT_CAL  = 2'd1,
    TGT_TALM = 2'd2,
    TGT_CALM = 2'd3
  } target_e;

  typedef struct packed {
    logic loadTime;
    logic loadCal;
    logic loadTalm;
    logic loadCalm;
    logic setTimeBad;
    logic clrTimeBad;
    logic setCalBad;
    logic clrCalBad;
  } strobes_t;

  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HOUR_LSB = 16;
  localparam int PM_BIT   = 22;
  localparam int DAY_LSB  = 0;
  localparam int MIN_DATA_W = PM_BIT + 1;
  localparam int FLAG_CNT = 2;

  function automatic logic bcdInRange(input logic [3:0] tens, input logic [3:0] units,
                                      input int unsigned lo, input int unsigned hi);
    int unsigned value;
    value = 32'(tens) * 10 + 32'(units);
    return (units <= 4'd9) && (value >= lo) && (value <= hi);
  endfunction

endpackage

// File: rtl/entryCheckDp.sv
module entryCheckDp
  import entryPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hour12Mode,
  input  strobes_t          strb,
  output logic              timeOk,
  output logic              calOk,
  output logic              timeBad,
  output logic              calBad
);

  logic [3:0] secTens, secUnits, minTens, minUnits, hourTens, hourUnits, dayVal;
  logic       pmBit;
  logic       secOk, minOk, hourOk, dayOk;

  always_comb begin
    secTens   = {1'b0, wrData[SEC_LSB+4 +: 3]};
    secUnits  = wrData[SEC_LSB +: 4];
    minTens   = {1'b0, wrData[MIN_LSB+4 +: 3]};
    minUnits  = wrData[MIN_LSB +: 4];
    hourTens  = {2'b00, wrData[HOUR_LSB+4 +: 2]};
    hourUnits = wrData[HOUR_LSB +: 4];
    pmBit     = wrData[PM_BIT];
    dayVal    = wrData[DAY_LSB +: 4];
  end

  always_comb begin
    secOk = bcdInRange(secTens, secUnits, 0, 59);
    minOk = bcdInRange(minTens, minUnits, 0, 59);
    if (hour12Mode) begin
      hourOk = bcdInRange(hourTens, hourUnits, 1, 12);
    end else begin
      hourOk = bcdInRange(hourTens, hourUnits, 0, 23) && !pmBit;
    end
    dayOk  = (dayVal >= 4'd1) && (dayVal <= 4'd7);
    timeOk = secOk && minOk && hourOk;
    calOk  = dayOk;
  end

  logic [FLAG_CNT-1:0] setVec, clrVec, flagQ;

  always_comb begin
    setVec = {strb.setCalBad, strb.setTimeBad};
    clrVec = {strb.clrCalBad, strb.clrTimeBad};
  end

  generate
    for (genvar f = 0; f < FLAG_CNT; f++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagQ[f] <= 1'b0;
        end else if (setVec[f]) begin
          flagQ[f] <= 1'b1;
        end else if (clrVec[f]) begin
          flagQ[f] <= 1'b0;
        end
      end
    end
  endgenerate

  assign timeBad = flagQ[0];
  assign calBad  = flagQ[1];

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(setVec[0] && clrVec[0]) && !(setVec[1] && clrVec[1])); // R8

endmodule

// File: rtl/entryCheckCtl.sv
module entryCheckCtl
  import entryPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStrobe,
  input  logic [1:0] wrTarget,
  input  logic       timeOk,
  input  logic       calOk,
  output strobes_t   strb
);

  target_e tgt;
  assign tgt = target_e'(wrTarget);

  always_comb begin
    strb = '0;
    if (wrStrobe) begin
      unique case (tgt)
        TGT_TIME: begin
          strb.loadTime   = timeOk;
          strb.setTimeBad = !timeOk;
          strb.clrTimeBad = timeOk;
        end
        TGT_CAL: begin
          strb.loadCal   = calOk;
          strb.setCalBad = !calOk;
          strb.clrCalBad = calOk;
        end
        TGT_TALM: strb.loadTalm = timeOk;
        TGT_CALM: strb.loadCalm = calOk;
        default: strb = '0;
      endcase
    end
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadTime, strb.loadCal, strb.loadTalm, strb.loadCalm})); // R6
  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> !(strb.loadTime || strb.loadCal || strb.loadTalm || strb.loadCalm)); // R6
  AST_ALARM_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrTarget[1]) |->
      !(strb.setTimeBad || strb.clrTimeBad || strb.setCalBad || strb.clrCalBad)); // R10

endmodule

// File: rtl/bcd_entry_validator.sv
module bcd_entry_validator
  import entryPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [1:0]        wrTarget,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hour12Mode,
  output logic              loadTime,
  output logic              loadCal,
  output logic              loadTimeAlarm,
  output logic              loadCalAlarm,
  output logic              timeBad,
  output logic              calBad
);

  strobes_t strb;
  logic     timeOk, calOk;

  entryCheckDp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .hour12Mode(hour12Mode),
    .strb(strb), .timeOk(timeOk), .calOk(calOk),
    .timeBad(timeBad), .calBad(calBad)
  );

  entryCheckCtl ctl_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrTarget(wrTarget),
    .timeOk(timeOk), .calOk(calOk), .strb(strb)
  );

  assign loadTime      = strb.loadTime;
  assign loadCal       = strb.loadCal;
  assign loadTimeAlarm = strb.loadTalm;
  assign loadCalAlarm  = strb.loadCalm;

  AST_TIME_FAIL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrTarget == TGT_TIME && !loadTime) |=> timeBad); // R8
  AST_TIME_PASS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    loadTime |=> !timeBad); // R8
  AST_TIME_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStrobe && wrTarget == TGT_TIME) |=> $stable(timeBad)); // R10
  AST_CAL_FAIL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrTarget == TGT_CAL && !loadCal) |=> calBad); // R9
  AST_CAL_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStrobe && wrTarget == TGT_CAL) |=> $stable(calBad)); // R9
  AST_NO_PM_IN_24H: assert property (@(posedge clk) disable iff (!rstN)
    ((loadTime || loadTimeAlarm) && !hour12Mode) |-> !wrData[PM_BIT]); // R2
  AST_DAY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (loadCal || loadCalAlarm) |-> (wrData[3:0] != 4'd0 && wrData[3:0] < 4'd8)); // R1

endmodule

// File: tb/bcd_entry_validator_tb_top.sv
module bcd_entry_validator_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [1:0]  wrTarget = 2'd0;
  logic [31:0] wrData = 32'd0;
  logic        hour12Mode = 1'b0;
  logic        loadTime, loadCal, loadTimeAlarm, loadCalAlarm, timeBad, calBad;

  int vecCount = 0;
  int badCount = 0;
  bit mTimeBad = 1'b0;
  bit mCalBad = 1'b0;

  always #10 clk = ~clk;

  bcd_entry_validator #(.DATA_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrTarget(wrTarget),
    .wrData(wrData), .hour12Mode(hour12Mode), .loadTime(loadTime),
    .loadCal(loadCal), .loadTimeAlarm(loadTimeAlarm), .loadCalAlarm(loadCalAlarm),
    .timeBad(timeBad), .calBad(calBad)
  );

  function automatic bit fieldOk(int tens, int units, int lo, int hi);
    int v;
    v = tens * 10 + units;
    return (units <= 9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic bit refTimeOk(logic [31:0] d, bit m12);
    bit s, m, h;
    s = fieldOk(int'(d[6:4]), int'(d[3:0]), 0, 59);
    m = fieldOk(int'(d[14:12]), int'(d[11:8]), 0, 59);
    if (m12) h = fieldOk(int'(d[21:20]), int'(d[19:16]), 1, 12);
    else     h = fieldOk(int'(d[21:20]), int'(d[19:16]), 0, 23) && (d[22] == 1'b0);
    return s && m && h;
  endfunction

  function automatic bit refDayOk(logic [31:0] d);
    return (int'(d[3:0]) >= 1) && (int'(d[3:0]) <= 7);
  endfunction

  task automatic compareNow(string tag, bit st, int tgt, logic [31:0] d, bit m12);
    bit ok;
    logic [5:0] exp, act;
    ok = (tgt[1] == 1'b0 && tgt[0] == 1'b0) || tgt == 2 ? refTimeOk(d, m12) : refDayOk(d);
    exp = 6'd0;
    if (st && ok) exp[2 + tgt] = 1'b1;
    exp[1] = mCalBad;
    exp[0] = mTimeBad;
    act = {loadCalAlarm, loadTimeAlarm, loadCal, loadTime, calBad, timeBad};
    vecCount++;
    if (act !== exp) begin
      badCount++;
      $display("FAIL %s: data=%h tgt=%0d m12=%0d actual=%b expected=%b",
               tag, d, tgt, m12, act, exp);
    end
  endtask

  task automatic applyVec(bit st, int tgt, logic [31:0] d, bit m12, string tag);
    bit ok;
    @(negedge clk);
    wrStrobe = st; wrTarget = 2'(tgt); wrData = d; hour12Mode = m12;
    #1;
    compareNow(tag, st, tgt, d, m12);
    ok = (tgt == 0 || tgt == 2) ? refTimeOk(d, m12) : refDayOk(d);
    @(posedge clk);
    if (rstN && st && tgt == 0) mTimeBad = !ok;
    if (rstN && st && tgt == 1) mCalBad = !ok;
    #1;
    wrStrobe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    mTimeBad = 1'b0; mCalBad = 1'b0;
    #1;
    compareNow("R11", 1'b0, 0, 32'd0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    badCount++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    compareNow("R11", 1'b0, 0, 32'd0, 1'b0);
    rstN = 1'b1;
    applyVec(0, 0, 32'h0000_0000, 0, "R11");
    applyVec(0, 0, 32'h0099_9999, 0, "R6");
    applyVec(1, 0, 32'h0023_5959, 0, "R2");
    applyVec(1, 0, 32'h0024_0000, 0, "R2");
    applyVec(1, 0, 32'h0012_0000, 1, "R3");
    applyVec(1, 0, 32'h0000_0000, 1, "R3");
    applyVec(1, 0, 32'h0041_0000, 0, "R2");
    applyVec(1, 0, 32'h0001_5A00, 0, "R4");
    applyVec(1, 0, 32'h0001_0060, 0, "R5");
    applyVec(1, 0, 32'h0001_000A, 0, "R5");
    applyVec(1, 0, 32'h0001_0101, 0, "R8");
    applyVec(1, 0, 32'hFF81_8181, 0, "R12");
    applyVec(1, 1, 32'hFFFF_FFF3, 0, "R12");
    applyVec(1, 1, 32'h0000_0008, 0, "R9");
    applyVec(1, 1, 32'h0000_0000, 0, "R1");
    applyVec(1, 3, 32'h0000_0009, 0, "R10");
    applyVec(1, 2, 32'h0025_0000, 0, "R10");
    applyVec(1, 1, 32'h0000_0007, 0, "R9");
    // fail time, then unrelated traffic, then a passing time write
    applyVec(1, 0, 32'h0000_6000, 0, "R7");
    applyVec(1, 2, 32'h0011_2233, 1, "R10");
    applyVec(1, 3, 32'h0000_0005, 0, "R10");
    applyVec(1, 1, 32'h0000_000F, 0, "R9");
    applyVec(1, 1, 32'h0000_0001, 0, "R9");
    applyVec(0, 0, 32'h0000_6000, 0, "R8");
    applyVec(1, 0, 32'h0009_0909, 0, "R8");
    for (int h = 0; h < 64; h++) begin
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 2; p++) begin
          applyVec(1, 0, (32'(h) << 16) | (32'(p) << 22) | 32'h0000_3030,
                   m[0], m[0] ? "R3" : "R2");
          applyVec(1, 2, (32'(h) << 16) | (32'(p) << 22), m[0], "R10");
        end
      end
    end
    for (int v = 0; v < 128; v++) begin
      applyVec(1, 0, 32'h0010_0000 | (32'(v) << 8), 0, "R4");
      applyVec(1, 0, 32'h0010_0000 | 32'(v), 1, "R5");
    end
    for (int v = 0; v < 16; v++) begin
      applyVec(1, 1, 32'(v), 0, "R1");
      applyVec(1, 3, 32'(v) | 32'hABCD_0000, 0, "R1");
    end
    applyVec(1, 0, 32'h0000_00FF, 0, "R8");
    applyVec(1, 1, 32'h0000_0000, 0, "R9");
    doReset();
    applyVec(0, 0, 32'h0, 0, "R11");
    applyVec(1, 0, 32'h0012_3456, 1, "R3");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end

endmodule